// File: doc/BRIEF.md
# Double-Linefill Read Burst Generator

This block turns each level-2 cache read miss into one read-address request on an AXI master port. It decides whether the miss fetches only the 32-byte line that holds the requested address, or a 64-byte pair of lines. It then sets the start address, the burst type, the burst length and the burst size of the outgoing request. It also reports the line addresses the burst will fill, so the fill logic knows which entries to allocate.

Each miss arrives as a single request with its original address, the incoming burst type, length and size, and a prefetch flag. Four static configuration bits shape the decision: doubling enable, a disable for doubling on unaligned wrap requests, an enable for incrementing doubling, and exclusive-cache mode. The block holds one request at a time. It keeps the request on the read-address channel, unchanged, until the channel accepts it.

Burst type encodings follow AXI: 2'b00 fixed, 2'b01 incrementing, 2'b10 wrapping. The length field is the number of beats minus one. The size field 3 means 8-byte beats.

Top module: `dlf_burst_gen`

## Requirements
- R1: After reset, `ar_valid` is 0 and `req_ready` is 1.
- R2: When `cfg_dbl_en` is 0, a request issues a wrapping burst (2'b10) of length 3 at the original address. `fill_line0` is the address rounded down to 32 bytes, and `fill_line1_vld` is 0.
- R3: With doubling allowed and `cfg_incr_dbl_en` at 0, an address whose bits [4:3] are zero issues a wrapping burst of length 7 at that address. `fill_line0` is the address rounded down to 64 bytes, and `fill_line1` is that value plus 32.
- R4: With doubling allowed, a nonzero address bits [4:3] and `cfg_wrap_dbl_dis` at 1, the request issues a wrapping burst of length 3 at the original unaligned address. Only one line is filled.
- R5: With doubling allowed, a nonzero address bits [4:3], `cfg_wrap_dbl_dis` at 0 and `cfg_incr_dbl_en` at 0, the request issues a wrapping burst of length 7 at the address rounded down to 32 bytes. The fill lines are the aligned 64-byte pair.
- R6: With doubling allowed and `cfg_incr_dbl_en` at 1, and not blocked by R4, the request issues an incrementing burst (2'b01) of length 7 at the address rounded down to 32 bytes. This holds in both halves of the 64-byte pair. The fill lines are that line and the line 32 bytes above it.
- R7: Doubling is allowed only when the incoming request is wrapping or incrementing, with length 3 and size 3. Any other request gets the single burst of R2.
- R8: An incrementing double fill whose second line would start in the next 4-Kbyte page falls back to the single burst of R2.
- R9: When both `req_prefetch` and `cfg_excl_mode` are 1, the request gets the single burst of R2.
- R10: `ar_size` is 3 on every issued request.
- R11: While `ar_valid` is 1 and `ar_ready` is 0, the address, burst, length, size and fill-line outputs do not change, and `req_ready` stays 0.
- R12: `ar_valid` rises in the cycle after a request is taken. It falls in the cycle after `ar_valid` and `ar_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Original read address |
| req_burst | input | 2 | Incoming burst type |
| req_len | input | 8 | Incoming burst length field |
| req_size | input | 3 | Incoming beat size field |
| req_prefetch | input | 1 | Request is a prefetch |
| cfg_dbl_en | input | 1 | Enable double linefill |
| cfg_wrap_dbl_dis | input | 1 | Do not double unaligned wrap requests |
| cfg_incr_dbl_en | input | 1 | Use incrementing double fills |
| cfg_excl_mode | input | 1 | Exclusive-cache mode |
| ar_valid | output | 1 | Read-address request valid |
| ar_ready | input | 1 | Read-address request accepted |
| ar_addr | output | ADDR_W | Burst start address |
| ar_burst | output | 2 | Burst type |
| ar_len | output | 8 | Burst length field |
| ar_size | output | 3 | Beat size field |
| fill_line0 | output | ADDR_W | First filled line address |
| fill_line1 | output | ADDR_W | Second filled line address |
| fill_line1_vld | output | 1 | Second line is filled |

## Verification
The 4-Kbyte page fallback is the hardest case to reach. It needs doubling allowed, incrementing doubling on, and the request in the last 32-byte line of a page. A stimulus that varies only the configuration almost never lands there. The sweep therefore uses a base address whose upper pair half is exactly that last line, and crosses every doubleword offset with all sixteen configurations, both prefetch values and four incoming burst shapes. The accept delay of the read-address channel also varies, so the hold-stable rule is checked over several waiting cycles.

// File: rtl/dlf_pkg.sv
// Shared constants for the double-linefill burst generator.
// Assumes AXI burst encodings and 8-byte data beats.
package dlf_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10
    } burst_e;

    localparam logic [2:0] SIZE_64 = 3'd3;
    localparam int         BEAT_BYTES = 8;
endpackage

// File: rtl/dlf_decide.sv
// Combinational fill decision: given a miss and the configuration, picks
// the start address, burst type, length and the filled line addresses.
// Assumes LINE_BYTES and PAGE_BYTES are powers of two, PAGE > 2*LINE.
module dlf_decide
    import dlf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        in_burst,
    input  logic [7:0]        in_len,
    input  logic [2:0]        in_size,
    input  logic              prefetch,
    input  logic              dbl_en,
    input  logic              wrap_dbl_dis,
    input  logic              incr_dbl_en,
    input  logic              excl_mode,
    output logic [ADDR_W-1:0] d_addr,
    output logic [1:0]        d_burst,
    output logic [7:0]        d_len,
    output logic [ADDR_W-1:0] d_line0,
    output logic [ADDR_W-1:0] d_line1,
    output logic              d_line1_vld
);
    localparam int LINE_W   = $clog2(LINE_BYTES);
    localparam int PAIR_W   = LINE_W + 1;
    localparam int PAGE_W   = $clog2(PAGE_BYTES);
    localparam int BEAT_W   = $clog2(BEAT_BYTES);
    localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
    localparam logic [7:0] LEN_ONE = 8'(BEATS - 1);
    localparam logic [7:0] LEN_TWO = 8'(2 * BEATS - 1);

    logic [ADDR_W-1:0] line_addr, pair_base, next_line;
    logic eligible, allowed, unaligned, last_in_page;

    // Derive the aligned addresses and the doubling conditions.
    always_comb begin
        line_addr    = {addr[ADDR_W-1:LINE_W], LINE_W'(0)};
        pair_base    = {addr[ADDR_W-1:PAIR_W], PAIR_W'(0)};
        next_line    = line_addr + ADDR_W'(LINE_BYTES);
        unaligned    = |addr[LINE_W-1:BEAT_W];
        last_in_page = &addr[PAGE_W-1:LINE_W];
        eligible     = ((in_burst == BT_WRAP) || (in_burst == BT_INCR)) &&
                       (in_len == LEN_ONE) && (in_size == SIZE_64);
        allowed      = dbl_en && eligible && !(prefetch && excl_mode);
    end

    // Select the burst shape: single, wrapped pair or incrementing pair.
    always_comb begin
        d_addr      = addr;
        d_burst     = BT_WRAP;
        d_len       = LEN_ONE;
        d_line0     = line_addr;
        d_line1     = next_line;
        d_line1_vld = 1'b0;
        if (allowed && !(unaligned && wrap_dbl_dis)) begin
            if (incr_dbl_en) begin
                if (!last_in_page) begin
                    d_addr      = line_addr;
                    d_burst     = BT_INCR;
                    d_len       = LEN_TWO;
                    d_line1_vld = 1'b1;
                end
            end else begin
                d_addr      = line_addr;
                d_len       = LEN_TWO;
                d_line0     = pair_base;
                d_line1     = pair_base + ADDR_W'(LINE_BYTES);
                d_line1_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dlf_ar_reg.sv
// Read-address output register: captures one decision and holds it on
// the channel until accepted. Assumes a single request in flight.
module dlf_ar_reg
    import dlf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [1:0]        d_burst,
    input  logic [7:0]        d_len,
    input  logic [ADDR_W-1:0] d_line0,
    input  logic [ADDR_W-1:0] d_line1,
    input  logic              d_line1_vld,
    input  logic              ar_ready,
    output logic              ar_valid,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [ADDR_W-1:0] fill_line0,
    output logic [ADDR_W-1:0] fill_line1,
    output logic              fill_line1_vld
);
    localparam int PAGE_LO = 12;

    // Track the channel valid flag through load and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ar_valid <= 1'b0;
        else if (load)                 ar_valid <= 1'b1;
        else if (ar_valid && ar_ready) ar_valid <= 1'b0;
    end

    // Capture the request fields when a new decision is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_addr        <= '0;
            ar_burst       <= BT_WRAP;
            ar_len         <= '0;
            ar_size        <= SIZE_64;
            fill_line0     <= '0;
            fill_line1     <= '0;
            fill_line1_vld <= 1'b0;
        end else if (load) begin
            ar_addr        <= d_addr;
            ar_burst       <= d_burst;
            ar_len         <= d_len;
            ar_size        <= SIZE_64;
            fill_line0     <= d_line0;
            fill_line1     <= d_line1;
            fill_line1_vld <= d_line1_vld;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> $stable(ar_addr) && $stable(ar_burst) &&
        $stable(ar_len) && $stable(fill_line0) && $stable(fill_line1) &&
        $stable(fill_line1_vld)); // R11
    AST_DROP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && ar_ready |=> !ar_valid); // R12
    AST_SIZE_64: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> ar_size == SIZE_64); // R10
    AST_SINGLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !fill_line1_vld |-> ar_burst == BT_WRAP && ar_len == 8'd3); // R2
    AST_LINES_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && fill_line1_vld |->
        fill_line1 - fill_line0 == ADDR_W'(LINE_BYTES)); // R6
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && fill_line1_vld |->
        fill_line0[ADDR_W-1:PAGE_LO] == fill_line1[ADDR_W-1:PAGE_LO]); // R8
endmodule

// File: rtl/dlf_burst_gen.sv
// Top: double-linefill read burst generator. Takes one miss at a time,
// decides single or double fill, and drives the read-address channel.
// Assumes static configuration while a request is outstanding.
module dlf_burst_gen
    import dlf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic [7:0]        req_len,
    input  logic [2:0]        req_size,
    input  logic              req_prefetch,
    input  logic              cfg_dbl_en,
    input  logic              cfg_wrap_dbl_dis,
    input  logic              cfg_incr_dbl_en,
    input  logic              cfg_excl_mode,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [1:0]        ar_burst,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [ADDR_W-1:0] fill_line0,
    output logic [ADDR_W-1:0] fill_line1,
    output logic              fill_line1_vld
);
    logic [ADDR_W-1:0] d_addr, d_line0, d_line1;
    logic [1:0]        d_burst;
    logic [7:0]        d_len;
    logic              d_line1_vld, load;

    // Accept a new miss only when the channel register is empty.
    always_comb begin
        req_ready = !ar_valid;
        load      = req_valid && req_ready;
    end

    dlf_decide #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) decide_i (
        .addr(req_addr), .in_burst(req_burst), .in_len(req_len), .in_size(req_size),
        .prefetch(req_prefetch), .dbl_en(cfg_dbl_en), .wrap_dbl_dis(cfg_wrap_dbl_dis),
        .incr_dbl_en(cfg_incr_dbl_en), .excl_mode(cfg_excl_mode),
        .d_addr(d_addr), .d_burst(d_burst), .d_len(d_len),
        .d_line0(d_line0), .d_line1(d_line1), .d_line1_vld(d_line1_vld)
    );

    dlf_ar_reg #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) ar_reg_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .d_addr(d_addr), .d_burst(d_burst), .d_len(d_len),
        .d_line0(d_line0), .d_line1(d_line1), .d_line1_vld(d_line1_vld),
        .ar_ready(ar_ready), .ar_valid(ar_valid), .ar_addr(ar_addr),
        .ar_burst(ar_burst), .ar_len(ar_len), .ar_size(ar_size),
        .fill_line0(fill_line0), .fill_line1(fill_line1), .fill_line1_vld(fill_line1_vld)
    );

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid); // R11
    AST_RISE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !ar_valid |=> ar_valid); // R12
endmodule

// File: tb/dlf_burst_gen_tb.sv
// Sweep bench: every doubleword offset of two address bases, all
// configurations, both prefetch values and four incoming burst shapes.
module dlf_burst_gen_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, ar_ready = 1'b0, req_prefetch = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_burst = 2'b10;
    logic [7:0]    req_len = 8'd3;
    logic [2:0]    req_size = 3'd3;
    logic          cfg_dbl_en = 0, cfg_wrap_dbl_dis = 0, cfg_incr_dbl_en = 0, cfg_excl_mode = 0;
    logic          req_ready, ar_valid, fill_line1_vld;
    logic [AW-1:0] ar_addr, fill_line0, fill_line1;
    logic [1:0]    ar_burst;
    logic [7:0]    ar_len;
    logic [2:0]    ar_size;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dlf_burst_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_burst(req_burst), .req_len(req_len), .req_size(req_size),
        .req_prefetch(req_prefetch), .cfg_dbl_en(cfg_dbl_en), .cfg_wrap_dbl_dis(cfg_wrap_dbl_dis),
        .cfg_incr_dbl_en(cfg_incr_dbl_en), .cfg_excl_mode(cfg_excl_mode),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_burst(ar_burst),
        .ar_len(ar_len), .ar_size(ar_size), .fill_line0(fill_line0),
        .fill_line1(fill_line1), .fill_line1_vld(fill_line1_vld)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // Expected outcome, written from the requirement list.
    logic [AW-1:0] e_addr, e_l0, e_l1;
    logic [1:0]    e_burst;
    logic [7:0]    e_len;
    logic          e_l1v;
    string         e_tag;

    task automatic model();
        logic [AW-1:0] line = req_addr & ~AW'(31);
        logic [AW-1:0] pair = req_addr & ~AW'(63);
        bit ok_shape = (req_burst == 2'b10 || req_burst == 2'b01) && req_len == 8'd3 && req_size == 3'd3;
        bit unal = (req_addr[4:3] != 2'b00);
        e_addr = req_addr; e_burst = 2'b10; e_len = 8'd3; e_l0 = line; e_l1 = '0; e_l1v = 0;
        if (!cfg_dbl_en)                       e_tag = "R2";
        else if (!ok_shape)                    e_tag = "R7";
        else if (req_prefetch && cfg_excl_mode) e_tag = "R9";
        else if (unal && cfg_wrap_dbl_dis)     e_tag = "R4";
        else if (cfg_incr_dbl_en) begin
            if (req_addr[11:5] == 7'h7F) e_tag = "R8";
            else begin
                e_tag = "R6"; e_addr = line; e_burst = 2'b01; e_len = 8'd7;
                e_l1 = line + 32; e_l1v = 1;
            end
        end else begin
            e_tag = unal ? "R5" : "R3";
            e_addr = line; e_len = 8'd7; e_l0 = pair; e_l1 = pair + 32; e_l1v = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] bases [2];
        int idx = 0;
        bases[0] = 32'h8000_1040;
        bases[1] = 32'h0001_0FC0;   // upper half is the last line of a page
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ar_valid == 0, "R1", $sformatf("%0b", ar_valid), "0");
        check(req_ready == 1, "R1", $sformatf("%0b", req_ready), "1");
        for (int b = 0; b < 2; b++)
        for (int off = 0; off < 8; off++)
        for (int cfg = 0; cfg < 16; cfg++)
        for (int pf = 0; pf < 2; pf++)
        for (int k = 0; k < 4; k++) begin
            req_addr = bases[b] + AW'(off * 8);
            {cfg_dbl_en, cfg_wrap_dbl_dis, cfg_incr_dbl_en, cfg_excl_mode} = 4'(cfg);
            req_prefetch = pf[0];
            case (k)
                0: begin req_burst = 2'b10; req_len = 8'd3; req_size = 3'd3; end
                1: begin req_burst = 2'b01; req_len = 8'd3; req_size = 3'd3; end
                2: begin req_burst = 2'b10; req_len = 8'd7; req_size = 3'd3; end
                default: begin req_burst = 2'b01; req_len = 8'd3; req_size = 3'd2; end
            endcase
            model();
            req_valid = 1'b1; ar_ready = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
            check(ar_valid == 1, "R12", $sformatf("%0b", ar_valid), "1");
            check(ar_addr == e_addr && ar_burst == e_burst && ar_len == e_len &&
                  fill_line0 == e_l0 && fill_line1_vld == e_l1v &&
                  (!e_l1v || fill_line1 == e_l1), e_tag,
                  $sformatf("a=%h b=%0d l=%0d l0=%h l1=%h v=%0b", ar_addr, ar_burst, ar_len, fill_line0, fill_line1, fill_line1_vld),
                  $sformatf("a=%h b=%0d l=%0d l0=%h l1=%h v=%0b", e_addr, e_burst, e_len, e_l0, e_l1, e_l1v));
            check(ar_size == 3'd3, "R10", $sformatf("%0d", ar_size), "3");
            // Hold: new stimulus on the request side must not disturb the channel.
            for (int w = 0; w < idx % 3; w++) begin
                req_valid = 1'b1; req_addr = ~req_addr;
                @(negedge clk);
                check(ar_valid && !req_ready && ar_addr == e_addr && ar_len == e_len &&
                      ar_burst == e_burst && fill_line0 == e_l0, "R11",
                      $sformatf("v=%0b rdy=%0b a=%h", ar_valid, req_ready, ar_addr),
                      $sformatf("v=1 rdy=0 a=%h", e_addr));
            end
            req_valid = 1'b0;
            ar_ready = 1'b1;
            @(negedge clk);
            ar_ready = 1'b0;
            check(ar_valid == 0 && req_ready == 1, "R12",
                  $sformatf("v=%0b rdy=%0b", ar_valid, req_ready), "v=0 rdy=1");
            idx++;
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule